// File: doc/BRIEF.md
# Parallel Flash Programming Controller

This block runs the parallel programming mode of an on-chip flash code store. A four-bit mode-select input and a high-voltage enable choose one of eight operations: chip erase, byte write, byte read, lock-bit write, lock-bit read, signature read, serial-programming fuse write, and fuse read. The operation starts on the falling edge of an active-low program strobe. The programming host supplies a 14-bit address and an 8-bit data word. It reads results from a data output that has its own output-enable.

Byte and lock writes take effect at the strobe's falling edge. They then hold the ready output low for a fixed number of cycles. Erase and fuse writes are timed operations. The strobe must stay low for a minimum number of clock cycles, and ready stays low for as long as the strobe is held. The operation commits when the strobe is released. A strobe released early leaves every stored value untouched. Flash cells only clear bits when written, so only an erase sets them back to ones.

Top module: `flash_par_prog`

## Requirements
- R1: `mode_sel[3:0]` (1 = high) selects the operation. The codes are: 1000 erase, 0111 byte write, 0011 byte read, 1010 lock write, 1100 lock read, 0000 signature read, 0101 fuse write, 1101 fuse read. Any other code does nothing.
- R2: After synchronous reset, the outputs are as follows: `ready` is 1 and `data_oe` is 0. Every byte reads 0xFF, the lock read gives 0xFF, and the fuse read gives 0xFE (serial programming enabled).
- R3: A byte write happens on a strobe falling edge while `hv_en` = 1. It stores `old & data_in` at the array entry. The entry is picked by the low MEM_AW bits of `addr`, so the upper address bits alias.
- R4: The controller ignores a strobe falling edge in a write, erase or fuse mode while `hv_en` = 0. It also ignores any strobe falling edge while `ready` is 0.
- R5: After a byte write or a lock write, `ready` is 0 for exactly WRITE_BUSY cycles.
- R6: A lock write programs lock 1, 2 and 3 when `data_in` bit 7, 6 and 5 respectively is 0. A lock read returns lock 1, 2 and 3 on bits 2, 1 and 0, where 0 means programmed. All other bits read 1.
- R7: A signature read returns MFR_CODE at address 0x0030 and DEV_CODE at address 0x0031. Any other address returns 0xFF.
- R8: An erase holds `ready` at 0 while the strobe is low. If the strobe was low for at least MIN_PULSE cycles, releasing it sets every byte to 0xFF and all locks to unprogrammed.
- R9: A fuse write latches `data_in` bit 0 at the strobe falling edge. If the pulse lasts at least MIN_PULSE cycles, that bit is stored at release. A fuse read returns the stored bit on bit 0, with all other bits 1.
- R10: If the strobe is released after fewer than MIN_PULSE cycles, an erase or fuse write changes nothing.
- R11: `data_oe` is 1 only in the four read modes, and only while `hv_en` = 0. `data_out` follows the mode and address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 4 | Operation select code |
| hv_en | input | 1 | High-voltage enable, required for write operations |
| prog_n | input | 1 | Active-low program strobe |
| addr | input | 14 | Byte address or signature index |
| data_in | input | 8 | Write data and lock or fuse control |
| data_out | output | 8 | Read data |
| data_oe | output | 1 | Output enable for `data_out` |
| ready | output | 1 | 1 = idle, 0 = operation in progress |

## Verification
The timing state sits between the strobe and the stored values. If that state were wrong, an erase or fuse write would commit on a short pulse, or be lost on a full one. The bench therefore tests pulse lengths of MIN_PULSE-1 and MIN_PULSE, and checks the very next read. A wrong busy counter shows directly as a `ready` low period of the wrong length. Because writes only clear bits, a missed write, an extra write or a wrong address shows up in the first read after the write. It also persists until the next erase.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

    localparam int ADDR_W = 14;
    localparam int DATA_W = 8;

    typedef enum logic [3:0] {
        OP_NONE, OP_ERASE, OP_WRITE, OP_READ,
        OP_LKW, OP_LKR, OP_SIG, OP_FUSE, OP_FUSER
    } op_e;

    typedef enum logic [1:0] {ST_IDLE, ST_PULSE, ST_WBUSY} st_e;

    // One-cycle commit strobes from the sequencer to the storage
    typedef struct packed {
        logic byte_we;
        logic lock_we;
        logic erase;
        logic fuse_we;
        logic fuse_val;
    } commit_t;

    function automatic op_e decode_mode(input logic [3:0] code);
        case (code)
            4'b1000: return OP_ERASE;
            4'b0111: return OP_WRITE;
            4'b0011: return OP_READ;
            4'b1010: return OP_LKW;
            4'b1100: return OP_LKR;
            4'b0000: return OP_SIG;
            4'b0101: return OP_FUSE;
            4'b1101: return OP_FUSER;
            default: return OP_NONE;
        endcase
    endfunction

    function automatic logic is_read(input op_e op);
        return (op == OP_READ) || (op == OP_LKR) || (op == OP_SIG) || (op == OP_FUSER);
    endfunction

    function automatic logic is_quick_write(input op_e op);
        return (op == OP_WRITE) || (op == OP_LKW);
    endfunction

    function automatic logic is_timed(input op_e op);
        return (op == OP_ERASE) || (op == OP_FUSE);
    endfunction

endpackage

// File: rtl/ppm_decode.sv
module ppm_decode
    import ppm_pkg::*;
(
    input  logic [3:0] mode_sel,
    input  logic       hv_en,
    output op_e        op,
    output logic       data_oe
);

    assign op      = decode_mode(mode_sel);
    assign data_oe = is_read(op) && !hv_en;

endmodule

// File: rtl/ppm_seq.sv
module ppm_seq
    import ppm_pkg::*;
#(
    parameter int MIN_PULSE  = 1000000,
    parameter int WRITE_BUSY = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    prog_n,
    input  logic    hv_en,
    input  op_e     op,
    input  logic    fuse_bit_in,
    output logic    ready,
    output commit_t cmt
);

    localparam int CNT_MAX = (MIN_PULSE > WRITE_BUSY) ? MIN_PULSE : WRITE_BUSY;
    localparam int CW      = $clog2(CNT_MAX + 1);

    st_e           st;
    logic [CW-1:0] cnt;
    logic          prog_q;
    logic          pend_erase;
    logic          pend_val;
    logic          fall;
    logic          long_enough;

    assign fall        = prog_q && !prog_n;
    assign long_enough = cnt >= CW'(MIN_PULSE);
    assign ready       = (st == ST_IDLE);

    always_comb begin
        cmt = '0;
        if (st == ST_IDLE && fall && hv_en) begin
            cmt.byte_we = (op == OP_WRITE);
            cmt.lock_we = (op == OP_LKW);
        end
        if (st == ST_PULSE && prog_n && long_enough) begin
            cmt.erase    = pend_erase;
            cmt.fuse_we  = !pend_erase;
            cmt.fuse_val = pend_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            prog_q     <= 1'b1;
            pend_erase <= 1'b0;
            pend_val   <= 1'b0;
        end else begin
            prog_q <= prog_n;
            case (st)
                ST_IDLE: begin
                    if (fall && hv_en) begin
                        if (is_quick_write(op)) begin
                            st  <= ST_WBUSY;
                            cnt <= CW'(1);
                        end else if (is_timed(op)) begin
                            st         <= ST_PULSE;
                            cnt        <= CW'(1);
                            pend_erase <= (op == OP_ERASE);
                            pend_val   <= fuse_bit_in;
                        end
                    end
                end
                ST_PULSE: begin
                    if (prog_n) st <= ST_IDLE;
                    else if (!long_enough) cnt <= cnt + 1'b1;
                end
                ST_WBUSY: begin
                    if (cnt == CW'(WRITE_BUSY)) st <= ST_IDLE;
                    else cnt <= cnt + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R4
    busy_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> ($past(hv_en) && !$past(prog_n)));

endmodule

// File: rtl/ppm_store.sv
module ppm_store
    import ppm_pkg::*;
#(
    parameter int          MEM_AW   = 8,
    parameter logic [7:0]  MFR_CODE = 8'hA5,
    parameter logic [7:0]  DEV_CODE = 8'h3C
) (
    input  logic              clk,
    input  logic              rst,
    input  commit_t           cmt,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [2:0]        lk_q;
    logic              fuse_q;
    logic [MEM_AW-1:0] idx;

    assign idx = addr[MEM_AW-1:0];

    always_ff @(posedge clk) begin
        if (rst || cmt.erase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (cmt.byte_we) begin
            mem[idx] <= mem[idx] & din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_q   <= 3'b111;
            fuse_q <= 1'b0;
        end else begin
            if (cmt.erase)        lk_q <= 3'b111;
            else if (cmt.lock_we) lk_q <= lk_q & din[7:5];
            if (cmt.fuse_we)      fuse_q <= cmt.fuse_val;
        end
    end

    always_comb begin
        case (op)
            OP_READ:  dout = mem[idx];
            OP_LKR:   dout = {5'h1F, lk_q};
            OP_FUSER: dout = {7'h7F, fuse_q};
            OP_SIG: begin
                if (addr == ADDR_W'('h30))      dout = MFR_CODE;
                else if (addr == ADDR_W'('h31)) dout = DEV_CODE;
                else                            dout = '1;
            end
            default:  dout = '1;
        endcase
    end

    // R8
    erase_clears_chk: assert property (@(posedge clk) disable iff (rst)
        cmt.erase |=> (lk_q == 3'b111 && mem[0] == 8'hFF));

    // R9
    fuse_store_chk: assert property (@(posedge clk) disable iff (rst)
        cmt.fuse_we |=> (fuse_q == $past(cmt.fuse_val)));

endmodule

// File: rtl/flash_par_prog.sv
module flash_par_prog
    import ppm_pkg::*;
#(
    parameter int         MEM_AW     = 8,
    parameter int         MIN_PULSE  = 1000000,
    parameter int         WRITE_BUSY = 8,
    parameter logic [7:0] MFR_CODE   = 8'hA5,
    parameter logic [7:0] DEV_CODE   = 8'h3C
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  mode_sel,
    input  logic        hv_en,
    input  logic        prog_n,
    input  logic [13:0] addr,
    input  logic [7:0]  data_in,
    output logic [7:0]  data_out,
    output logic        data_oe,
    output logic        ready
);

    op_e     op;
    commit_t cmt;

    ppm_decode u_dec (
        .mode_sel (mode_sel),
        .hv_en    (hv_en),
        .op       (op),
        .data_oe  (data_oe)
    );

    ppm_seq #(
        .MIN_PULSE  (MIN_PULSE),
        .WRITE_BUSY (WRITE_BUSY)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .prog_n      (prog_n),
        .hv_en       (hv_en),
        .op          (op),
        .fuse_bit_in (data_in[0]),
        .ready       (ready),
        .cmt         (cmt)
    );

    ppm_store #(
        .MEM_AW   (MEM_AW),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_store (
        .clk  (clk),
        .rst  (rst),
        .cmt  (cmt),
        .op   (op),
        .addr (addr),
        .din  (data_in),
        .dout (data_out)
    );

    // R11
    oe_no_hv_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> !hv_en);

    // R4
    write_needs_hv_chk: assert property (@(posedge clk) disable iff (rst)
        (cmt.byte_we || cmt.lock_we) |-> (hv_en && ready));

endmodule

// File: tb/flash_par_prog_tb.sv
module flash_par_prog_tb;

    localparam int MINP  = 20;
    localparam int WBUSY = 4;
    localparam logic [3:0] M_ERASE = 4'b1000, M_WRITE = 4'b0111, M_READ = 4'b0011,
                           M_LKW = 4'b1010, M_LKR = 4'b1100, M_SIG = 4'b0000,
                           M_FUSE = 4'b0101, M_FUSER = 4'b1101;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  mode_sel = 4'b1111;
    logic        hv_en = 1'b0;
    logic        prog_n = 1'b1;
    logic [13:0] addr = '0;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic        data_oe;
    logic        ready;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    flash_par_prog #(
        .MEM_AW (8), .MIN_PULSE (MINP), .WRITE_BUSY (WBUSY),
        .MFR_CODE (8'hA5), .DEV_CODE (8'h3C)
    ) u_dut (
        .clk (clk), .rst (rst), .mode_sel (mode_sel), .hv_en (hv_en),
        .prog_n (prog_n), .addr (addr), .data_in (data_in),
        .data_out (data_out), .data_oe (data_oe), .ready (ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] code, input logic [13:0] a, output logic [7:0] v);
        @(negedge clk);
        mode_sel = code; hv_en = 1'b0; addr = a;
        #1 v = data_out;
    endtask

    task automatic strobe(input logic [3:0] code, input logic hv, input logic [13:0] a,
                          input logic [7:0] d, output int busy);
        @(negedge clk);
        mode_sel = code; hv_en = hv; addr = a; data_in = d; prog_n = 1'b0;
        @(negedge clk);
        prog_n = 1'b1;
        busy = 0;
        while (!ready && busy < 100) begin
            busy++;
            @(negedge clk);
        end
    endtask

    task automatic pulse(input logic [3:0] code, input logic [7:0] d, input int n, input string req);
        @(negedge clk);
        mode_sel = code; hv_en = 1'b1; data_in = d; prog_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == n / 2) chk({req, " ready low during pulse"}, ready, 0);
        end
        prog_n = 1'b1;
        @(negedge clk);
        chk({req, " ready after release"}, ready, 1);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R2 ready", ready, 1);
        chk("R2 oe", data_oe, 0);
        rd(M_READ, 14'h0005, v);  chk("R2 mem", v, 8'hFF);
        rd(M_LKR, 14'h0, v);      chk("R2 lock", v, 8'hFF);
        rd(M_FUSER, 14'h0, v);    chk("R2 fuse", v, 8'hFE);
    endtask

    task automatic t_write();
        logic [7:0] v;
        int b;
        strobe(M_WRITE, 1'b1, 14'h0123, 8'h5A, b);
        chk("R5 byte busy", b, WBUSY);
        rd(M_READ, 14'h0123, v);  chk("R3 write", v, 8'h5A);
        chk("R1 read mode oe", data_oe, 1);
        strobe(M_WRITE, 1'b1, 14'h0123, 8'hF0, b);
        rd(M_READ, 14'h0123, v);  chk("R3 and-write", v, 8'h50);
        rd(M_READ, 14'h3F23, v);  chk("R3 alias", v, 8'h50);
    endtask

    task automatic t_ignore();
        logic [7:0] v;
        int b;
        strobe(M_WRITE, 1'b0, 14'h0010, 8'h00, b);
        chk("R4 no hv busy", b, 0);
        rd(M_READ, 14'h0010, v);  chk("R4 no hv write", v, 8'hFF);
        strobe(M_LKW, 1'b0, 14'h0, 8'h00, b);
        rd(M_LKR, 14'h0, v);      chk("R4 no hv lock", v, 8'hFF);
        @(negedge clk);
        mode_sel = M_WRITE; hv_en = 1'b1; addr = 14'h0011; data_in = 8'h0F; prog_n = 1'b0;
        @(negedge clk) prog_n = 1'b1;
        @(negedge clk);
        addr = 14'h0012; data_in = 8'h00; prog_n = 1'b0;
        @(negedge clk) prog_n = 1'b1;
        b = 0;
        while (!ready && b < 100) begin b++; @(negedge clk); end
        rd(M_READ, 14'h0012, v);  chk("R4 strobe while busy", v, 8'hFF);
        rd(M_READ, 14'h0011, v);  chk("R3 first write kept", v, 8'h0F);
        strobe(4'b1111, 1'b1, 14'h0011, 8'h00, b);
        chk("R1 unused code busy", b, 0);
        rd(M_READ, 14'h0011, v);  chk("R1 unused code no write", v, 8'h0F);
    endtask

    task automatic t_lock();
        logic [7:0] v;
        int b;
        strobe(M_LKW, 1'b1, 14'h0, 8'h7F, b);
        chk("R5 lock busy", b, WBUSY);
        rd(M_LKR, 14'h0, v);      chk("R6 lock1", v, 8'hFB);
        strobe(M_LKW, 1'b1, 14'h0, 8'hDF, b);
        rd(M_LKR, 14'h0, v);      chk("R6 lock3", v, 8'hFA);
    endtask

    task automatic t_sig();
        logic [7:0] v;
        rd(M_SIG, 14'h0030, v);   chk("R7 mfr", v, 8'hA5);
        rd(M_SIG, 14'h0031, v);   chk("R7 dev", v, 8'h3C);
        rd(M_SIG, 14'h0032, v);   chk("R7 other", v, 8'hFF);
    endtask

    task automatic t_oe();
        @(negedge clk); mode_sel = M_READ; hv_en = 1'b1;
        #1 chk("R11 read with hv", data_oe, 0);
        @(negedge clk); mode_sel = M_LKW; hv_en = 1'b0;
        #1 chk("R11 write mode", data_oe, 0);
        @(negedge clk); mode_sel = M_SIG;
        #1 chk("R11 sig mode", data_oe, 1);
        @(negedge clk); mode_sel = M_FUSER;
        #1 chk("R11 fuse read mode", data_oe, 1);
    endtask

    task automatic t_fuse();
        logic [7:0] v;
        pulse(M_FUSE, 8'h01, MINP - 1, "R10 fuse");
        rd(M_FUSER, 14'h0, v);    chk("R10 short fuse", v, 8'hFE);
        pulse(M_FUSE, 8'h01, MINP, "R9 fuse");
        rd(M_FUSER, 14'h0, v);    chk("R9 fuse set", v, 8'hFF);
        pulse(M_FUSE, 8'h00, MINP + 10, "R9 fuse");
        rd(M_FUSER, 14'h0, v);    chk("R9 fuse clear", v, 8'hFE);
    endtask

    task automatic t_erase();
        logic [7:0] v;
        pulse(M_ERASE, 8'h00, MINP - 1, "R10 erase");
        rd(M_READ, 14'h0123, v);  chk("R10 short erase mem", v, 8'h50);
        rd(M_LKR, 14'h0, v);      chk("R10 short erase lock", v, 8'hFA);
        pulse(M_ERASE, 8'h00, MINP, "R8 erase");
        rd(M_READ, 14'h0123, v);  chk("R8 erase mem", v, 8'hFF);
        rd(M_READ, 14'h0011, v);  chk("R8 erase mem2", v, 8'hFF);
        rd(M_LKR, 14'h0, v);      chk("R8 erase lock", v, 8'hFF);
        rd(M_FUSER, 14'h0, v);    chk("R8 fuse kept", v, 8'hFE);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write();
        t_ignore();
        t_lock();
        t_sig();
        t_oe();
        t_fuse();
        t_erase();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule